// File: doc/BRIEF.md
# Chain Source Reset Sequencer

This block sits at the head of a synchronous test chain of 16-bit processing devices and acts as its master data source. When a start request arrives, it drives an active-low chain reset for a programmable number of timeslots, never fewer than sixteen. It then releases the reset and holds the bus unmarked for a fixed guard interval of 1600 timeslots. After that it streams words from an internal incrementing counter, one marked word per slot.

Every output changes only on the rising clock edge, so neighbouring devices can sample data, mark and reset on the falling edge. With the default values and a 16 kHz slot clock, the minimum sequence takes 1616 slots: 1 ms of reset followed by 100 ms of silence. A pause input can leave individual slots unmarked while streaming. Start requests that arrive during the reset or the guard interval are ignored. A start request during streaming begins a fresh sequence.

Top module: `chain_src_seq`

## Requirements
- R1: A start request sampled while idle or streaming drives `chain_rst_n` low in the slot that directly follows that rising edge.
- R2: `chain_rst_n` stays low for exactly `max(assert_len, 16)` consecutive slots, with `assert_len` sampled at the accepted start, and then returns high.
- R3: An `assert_len` value below 16, including 0, yields exactly 16 low slots.
- R4: Once `chain_rst_n` returns high, exactly 1600 unmarked slots pass before the first marked slot.
- R5: `mark_o` is 0 in every slot where `chain_rst_n` is low or the guard interval is running, and `data_o` is 0 in every unmarked slot.
- R6: The first marked word after a sequence is 0, and each later marked word is the previous marked word plus 1, wrapping modulo 2^16.
- R7: While streaming, a slot whose rising edge sees `pause` high is unmarked, and the count does not advance.
- R8: A start request sampled during the reset or guard phase has no effect on timing. A start request sampled while streaming restarts the sequence, with the word count reset to 0.
- R9: `busy_o` is high from the slot after an accepted start until the first marked slot, where it drops to 0. `streaming_o` is high from the end of the guard interval until the next restart.
- R10: After local reset, `chain_rst_n` is 1 and `mark_o`, `data_o`, `busy_o` and `streaming_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; every rising edge starts a timeslot |
| rst_n | input | 1 | Local asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Request to begin a chain reset sequence |
| assert_len | input | 8 | Requested reset length in slots, clamped up to 16 |
| pause | input | 1 | While streaming, leaves the current slot unmarked |
| chain_rst_n | output | 1 | Active-low reset driven to the chain |
| data_o | output | 16 | Data word of the current slot |
| mark_o | output | 1 | Valid mark of the current slot |
| busy_o | output | 1 | Sequence running, no marked slot yet |
| streaming_o | output | 1 | Guard interval over, generator active |

## Verification
The in-RTL assertions watch several rules on every cycle. Each low phase of the chain reset must last at least the minimum. The first mark must come after exactly 1600 quiet slots. No slot may be marked while reset is low or busy is high. Consecutive marked words must step by one. A start during the guard must leave the reset high. The exact low length for a given `assert_len`, the clamp, the value of the first word, the effect of pause and the restart from streaming are shown only by the bench scenarios. There, a behavioural model is compared with the outputs on every slot, and the reset-low and guard slots are counted directly.

// File: rtl/csrs_pkg.sv
package csrs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ASSERT = 2'd1,
    PH_GUARD  = 2'd2,
    PH_RUN    = 2'd3
  } phase_t;
endpackage

// File: rtl/csrs_rst_sync.sv
// Asynchronous assert, synchronous release of the local reset.
module csrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/csrs_slot_timer.sv
// Down-counter of slots; reports when the current count is zero.
module csrs_slot_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/csrs_word_gen.sv
// Incrementing test-word generator.
module csrs_word_gen #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (clear)        word_d = '0;
    else if (advance) word_d = word_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/chain_src_seq.sv
module chain_src_seq
  import csrs_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 8,
  parameter int MIN_ASSERT  = 16,
  parameter int GUARD_SLOTS = 1600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [LEN_W-1:0]  assert_len,
  input  logic              pause,
  output logic              chain_rst_n,
  output logic [DATA_W-1:0] data_o,
  output logic              mark_o,
  output logic              busy_o,
  output logic              streaming_o
);
  localparam int LEN_MAX = (1 << LEN_W) - 1;
  localparam int SPAN    = (GUARD_SLOTS > LEN_MAX) ? GUARD_SLOTS : LEN_MAX;
  localparam int CNT_W   = $clog2(SPAN + 1) + 1;

  logic srst_n;
  phase_t phase_q, phase_d;
  logic chain_rst_q, chain_rst_d;
  logic mark_q, mark_d;
  logic busy_q, busy_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic tmr_load, tmr_en, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic gen_clear, gen_adv;
  logic [DATA_W-1:0] gen_word;
  logic [LEN_W-1:0] len_eff;

  csrs_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  csrs_slot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .srst_n(srst_n), .load(tmr_load), .load_val(tmr_val),
    .en(tmr_en), .is_zero(tmr_zero)
  );

  csrs_word_gen #(.DATA_W(DATA_W)) u_gen (
    .clk(clk), .srst_n(srst_n), .clear(gen_clear), .advance(gen_adv),
    .word(gen_word)
  );

  assign len_eff = (assert_len < LEN_W'(MIN_ASSERT)) ? LEN_W'(MIN_ASSERT) : assert_len;

  always_comb begin
    phase_d     = phase_q;
    chain_rst_d = chain_rst_q;
    mark_d      = 1'b0;
    busy_d      = busy_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    tmr_en      = 1'b0;
    gen_clear   = 1'b0;
    gen_adv     = 1'b0;
    unique case (phase_q)
      PH_ASSERT: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          phase_d     = PH_GUARD;
          chain_rst_d = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = CNT_W'(GUARD_SLOTS - 1);
        end
      end
      PH_GUARD: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          phase_d = PH_RUN;
          mark_d  = !pause;
          gen_adv = !pause;
          if (!pause) busy_d = 1'b0;
        end
      end
      default: begin // idle or streaming
        if (start_req) begin
          phase_d     = PH_ASSERT;
          chain_rst_d = 1'b0;
          busy_d      = 1'b1;
          tmr_load    = 1'b1;
          tmr_val     = CNT_W'(len_eff) - 1'b1;
          gen_clear   = 1'b1;
        end else if (phase_q == PH_RUN) begin
          mark_d  = !pause;
          gen_adv = !pause;
          if (!pause) busy_d = 1'b0;
        end
      end
    endcase
    data_d = mark_d ? gen_word : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q     <= PH_IDLE;
      chain_rst_q <= 1'b1;
      mark_q      <= 1'b0;
      busy_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      phase_q     <= phase_d;
      chain_rst_q <= chain_rst_d;
      mark_q      <= mark_d;
      busy_q      <= busy_d;
      data_q      <= data_d;
    end
  end

  assign chain_rst_n = chain_rst_q;
  assign mark_o      = mark_q;
  assign busy_o      = busy_q;
  assign data_o      = data_q;
  assign streaming_o = (phase_q == PH_RUN);

  // ---------------- assertion support counters ----------------
  logic [CNT_W-1:0] low_run_q, guard_run_q;
  logic rst_prev_q, seen_mark_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      low_run_q   <= '0;
      guard_run_q <= '0;
      rst_prev_q  <= 1'b1;
      seen_mark_q <= 1'b0;
    end else begin
      rst_prev_q <= chain_rst_q;
      low_run_q  <= chain_rst_q ? '0 : low_run_q + 1'b1;
      if (!chain_rst_q)                       guard_run_q <= '0;
      else if (!mark_q && !seen_mark_q && guard_run_q != '1)
                                              guard_run_q <= guard_run_q + 1'b1;
      if (!chain_rst_q)  seen_mark_q <= 1'b0;
      else if (mark_q)   seen_mark_q <= 1'b1;
    end
  end

  AST_RESET_MIN_LEN: assert property (@(posedge clk) disable iff (!srst_n)
    (chain_rst_q && !rst_prev_q) |-> (low_run_q >= CNT_W'(MIN_ASSERT))); // R2
  AST_GUARD_EXACT: assert property (@(posedge clk) disable iff (!srst_n)
    (mark_q && !seen_mark_q) |-> (guard_run_q == CNT_W'(GUARD_SLOTS))); // R4
  AST_NO_MARK_IN_RESET: assert property (@(posedge clk) disable iff (!srst_n)
    !chain_rst_q |-> !mark_q); // R5
  AST_BUSY_UNMARKED: assert property (@(posedge clk) disable iff (!srst_n)
    busy_q |-> !mark_q); // R9
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (mark_q && $past(mark_q)) |-> (data_q == $past(data_q) + 1'b1)); // R6
  AST_GUARD_START_IGNORED: assert property (@(posedge clk) disable iff (!srst_n)
    (phase_q == PH_GUARD && start_req) |=> chain_rst_q); // R8
endmodule

// File: tb/tb_chain_src_seq.sv
`timescale 1ns/1ps
module tb_chain_src_seq;
  localparam int GUARD = 1600;
  localparam int MINL  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [7:0] assert_len = 8'd0;
  logic pause = 1'b0;
  logic chain_rst_n, mark_o, busy_o, streaming_o;
  logic [15:0] data_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  chain_src_seq dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .assert_len(assert_len),
    .pause(pause), .chain_rst_n(chain_rst_n), .data_o(data_o), .mark_o(mark_o),
    .busy_o(busy_o), .streaming_o(streaming_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: phase 0 idle, 1 reset low, 2 guard, 3 streaming
  int m_phase = 0, m_left = 0, m_word = 0;
  bit m_rst = 1, m_mark = 0, m_busy = 0;
  int m_data = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_word = 0;
      m_rst = 1; m_mark = 0; m_busy = 0; m_data = 0;
    end else begin
      m_mark = 0; m_data = 0;
      if ((m_phase == 0 || m_phase == 3) && start_req) begin
        m_phase = 1;
        m_left  = (assert_len < MINL) ? MINL : assert_len;
        m_word  = 0; m_rst = 0; m_busy = 1;
      end else if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin m_phase = 2; m_left = GUARD; m_rst = 1; end
      end else begin
        if (m_phase == 2) begin
          m_left--;
          if (m_left == 0) m_phase = 3;
        end
        if (m_phase == 3 && !(m_left == 0 && m_phase == 2)) begin
          if (!pause) begin
            m_mark = 1; m_data = m_word;
            m_word = (m_word + 1) % 65536; m_busy = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(chain_rst_n == m_rst, "R2 chain_rst_n", chain_rst_n, m_rst);
      chk(mark_o == m_mark,     "R5 mark_o", mark_o, m_mark);
      chk(data_o == m_data,     "R6 data_o", data_o, m_data);
      chk(busy_o == m_busy,     "R9 busy_o", busy_o, m_busy);
      chk(streaming_o == (m_phase == 3), "R9 streaming_o", streaming_o, m_phase == 3);
    end
  end

  task automatic run_seq(input int len, input bit poke, input int exp_low);
    int low, g;
    @(negedge clk);
    assert_len = 8'(len);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(chain_rst_n == 1'b0, "R1 reset low after start", chain_rst_n, 0);
    low = 0;
    while (!chain_rst_n && low < 1000) begin
      low++;
      start_req = poke && (low == 3);
      @(negedge clk);
    end
    start_req = 1'b0;
    chk(low == exp_low, (len < MINL) ? "R3 clamped low length" : "R2 low length", low, exp_low);
    g = 0;
    while (!mark_o && g < 5000) begin
      g++;
      start_req = poke && (g == 100);
      @(negedge clk);
    end
    start_req = 1'b0;
    chk(g == GUARD, poke ? "R8 guard length with ignored start" : "R4 guard length", g, GUARD);
    chk(data_o == 16'd0, "R6 first word", data_o, 0);
  endtask

  initial begin
    int last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(chain_rst_n == 1'b1, "R10 chain_rst_n", chain_rst_n, 1);
    chk(mark_o == 1'b0,      "R10 mark_o", mark_o, 0);
    chk(data_o == 16'd0,     "R10 data_o", data_o, 0);
    chk(busy_o == 1'b0,      "R10 busy_o", busy_o, 0);
    chk(streaming_o == 1'b0, "R10 streaming_o", streaming_o, 0);

    run_seq(16, 1'b0, 16);
    repeat (10) @(negedge clk);
    chk(data_o == 16'd10, "R6 tenth step", data_o, 10);

    last = data_o;
    pause = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(mark_o == 1'b0, "R7 paused slot unmarked", mark_o, 0);
    end
    pause = 1'b0;
    @(negedge clk);
    chk(data_o == last + 1, "R7 count held over pause", data_o, last + 1);

    run_seq(5, 1'b0, 16);
    run_seq(0, 1'b0, 16);
    run_seq(40, 1'b1, 40);
    repeat (20) @(negedge clk);
    run_seq(17, 1'b0, 17);
    repeat (5) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    done = 1;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule